// File: doc/BRIEF.md
# Memory Request Range Router with Node Interleave

This block picks the destination node for a physical memory request with a 40-bit address. It holds a configurable number of address windows, eight by default. Each window is set by a pair of 32-bit registers: a low-bound register and a high-bound register. A window claims a request only when all of the following hold:

- The request address lies within the window's bounds.
- The window allows the access type (read or write).
- The low address bits selected by the window's interleave mask equal the window's programmed interleave value.

When a window claims a request, the block reports a hit, the window's destination node and the window's index. When no window claims it, the block reports a miss.

Software loads the windows through a plain register port. Writes are synchronous. Reads are combinational. The access enables live in the low-bound register, so a window stays inert until that register is written with an enable set. The high-bound register is therefore loaded first. Each request on `req_valid` returns a registered result in the next cycle.

Top module: `mem_route_decoder`

## Requirements
- R1: A request presented with `req_valid` high at a clock edge produces `rsp_valid` high exactly one cycle later. A cycle without a request leaves `rsp_valid`, `rsp_hit`, `rsp_node` and `rsp_pair` at zero in the following cycle.
- R2: A window covers request address bits 39:24 inclusively, from its low-bound field to its high-bound field. Each field sits in bits 31:16 of its register, giving 16 MB granularity.
- R3: Low-bound bit 0 allows reads and bit 1 allows writes. A window whose enable for the request type (`req_write`) is clear never claims it.
- R4: On a hit, `rsp_node` carries high-bound bits 2:0 of the claiming window, and `rsp_pair` carries its index.
- R5: Low-bound bits 10:8 are an interleave mask over address bits 14:12, and high-bound bits 10:8 are the value compared with them. Code 000 means no interleave, 001 tests A12, 011 tests A13:12, and 111 tests A14:12. A window claims a request only if the masked bits are equal.
- R6: A window whose mask code is any other value (010, 100, 101, 110) never claims a request.
- R7: When several windows claim a request, the window with the lowest index wins.
- R8: A miss reports `rsp_hit` low with `rsp_node` and `rsp_pair` at zero.
- R9: Register address map and stored bits:
  - `cfg_addr` bit 3 clear selects the low-bound register of window `cfg_addr[2:0]`; bit 3 set selects the high-bound register.
  - Only bits 31:16, 10:8 and 1:0 of a low-bound register are stored.
  - Only bits 31:16, 10:8 and 2:0 of a high-bound register are stored.
  - All other bits read as zero, whatever was written.
- R10: Reset, synchronous and active-high, clears every register to zero. After reset, all windows are disabled and every request misses.
- R11: A request in the same cycle as a register write is decoded with the register values from before that write. The write affects requests from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Physical request address |
| req_write | input | 1 | 1 = write request, 0 = read request |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select (bit 3: high-bound, bits 2:0: window) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_node | output | 3 | Destination node of the claiming window, zero on a miss |
| rsp_pair | output | 3 | Index of the claiming window, zero on a miss |

## Verification
The assertions assume three things about the inputs:

- Reset is applied before the first request.
- `req_valid`, `req_write`, `cfg_we` and `cfg_addr` carry known values once reset is released.
- Any value of `cfg_addr` names a real register, which holds at the default of eight windows.

The stimulus drives every input on the falling clock edge, so each input is stable at the sampling edge, and it keeps all of them defined from time zero. Register writes are deliberately placed in the same cycle as requests, so the old-value rule of R11 is exercised within these assumptions.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int ADDR_W    = 40;
    localparam int REG_W     = 32;
    localparam int NODE_W    = 3;
    localparam int ILV_W     = 3;
    localparam int ILV_LSB   = 12;
    localparam int FIELD_W   = 16;
    localparam int FIELD_LSB = 24;

    localparam logic [REG_W-1:0] LO_KEEP = 32'hFFFF_0703;
    localparam logic [REG_W-1:0] HI_KEEP = 32'hFFFF_0707;

    typedef struct packed {
        logic [FIELD_W-1:0] bound;
        logic [4:0]         rsv_hi;
        logic [ILV_W-1:0]   ilv_mask;
        logic [5:0]         rsv_lo;
        logic               wr_ok;
        logic               rd_ok;
    } lo_reg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] bound;
        logic [4:0]         rsv_hi;
        logic [ILV_W-1:0]   ilv_value;
        logic [4:0]         rsv_lo;
        logic [NODE_W-1:0]  node;
    } hi_reg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic [ILV_W-1:0]   ilv_bits;
        logic               is_write;
    } probe_t;

    function automatic logic mask_code_legal(input logic [ILV_W-1:0] code);
        return (code == 3'b000) || (code == 3'b001) ||
               (code == 3'b011) || (code == 3'b111);
    endfunction

    function automatic probe_t make_probe(input logic [ADDR_W-1:0] addr,
                                          input logic wr);
        probe_t p;
        p.field    = addr[FIELD_LSB +: FIELD_W];
        p.ilv_bits = addr[ILV_LSB +: ILV_W];
        p.is_write = wr;
        return p;
    endfunction

endpackage

// File: rtl/mrd_regfile.sv
module mrd_regfile
    import mrd_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int CFG_AW   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output lo_reg_t           lo_o [NUM_PAIRS],
    output hi_reg_t           hi_o [NUM_PAIRS]
);

    logic [REG_W-1:0] lo_q [NUM_PAIRS];
    logic [REG_W-1:0] hi_q [NUM_PAIRS];

    logic             sel_hi;
    logic [IDX_W-1:0] sel_idx;

    assign sel_hi  = cfg_addr[CFG_AW-1];
    assign sel_idx = cfg_addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end else if (cfg_we && (sel_idx == IDX_W'(g))) begin
                if (sel_hi) hi_q[g] <= cfg_wdata & HI_KEEP;
                else        lo_q[g] <= cfg_wdata & LO_KEEP;
            end
        end

        assign lo_o[g] = lo_reg_t'(lo_q[g]);
        assign hi_o[g] = hi_reg_t'(hi_q[g]);

        // R9: a write lands in the named register with reserved bits dropped
        a_r9_lo_store: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !sel_hi && sel_idx == IDX_W'(g))
            |=> lo_q[g] == ($past(cfg_wdata) & LO_KEEP));
        a_r9_hi_store: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && sel_hi && sel_idx == IDX_W'(g))
            |=> hi_q[g] == ($past(cfg_wdata) & HI_KEEP));
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (sel_idx == IDX_W'(i)) cfg_rdata = sel_hi ? hi_q[i] : lo_q[i];
        end
    end

endmodule

// File: rtl/mrd_pair_match.sv
module mrd_pair_match
    import mrd_pkg::*;
(
    input  lo_reg_t lo_i,
    input  hi_reg_t hi_i,
    input  probe_t  probe_i,
    output logic    match_o
);

    logic access_ok;
    logic in_window;
    logic ilv_ok;
    logic code_ok;

    always_comb begin
        access_ok = probe_i.is_write ? lo_i.wr_ok : lo_i.rd_ok;
        in_window = (probe_i.field >= lo_i.bound) && (probe_i.field <= hi_i.bound);
        code_ok   = mask_code_legal(lo_i.ilv_mask);
        ilv_ok    = ((probe_i.ilv_bits ^ hi_i.ilv_value) & lo_i.ilv_mask) == '0;
        match_o   = access_ok && in_window && code_ok && ilv_ok;
    end

    always_comb begin
        // R3: a disabled access type never matches
        if (access_ok === 1'b0) a_r3_access_gate: assert (match_o == 1'b0);
        // R6: a reserved interleave code never matches
        if (code_ok === 1'b0) a_r6_reserved_code: assert (match_o == 1'b0);
    end

endmodule

// File: rtl/mrd_prio_select.sv
module mrd_prio_select
    import mrd_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic [NUM_PAIRS-1:0]             match_i,
    input  logic [NUM_PAIRS-1:0][NODE_W-1:0] node_i,
    output logic                             hit_o,
    output logic [NODE_W-1:0]                node_o,
    output logic [IDX_W-1:0]                 idx_o
);

    logic [NUM_PAIRS-1:0] grant;
    logic [NUM_PAIRS-1:0] lower_seen;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_grant
        if (g == 0) begin : g_first
            assign lower_seen[g] = 1'b0;
        end else begin : g_rest
            assign lower_seen[g] = lower_seen[g-1] | match_i[g-1];
        end
        assign grant[g] = match_i[g] & ~lower_seen[g];
    end

    always_comb begin
        hit_o  = |match_i;
        node_o = '0;
        idx_o  = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (grant[i]) begin
                node_o = node_i[i];
                idx_o  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        // R7: at most one window wins, and a winner exists whenever any matched
        if (!$isunknown(match_i)) begin
            a_r7_single_winner: assert ($onehot0(grant) && ((|grant) == (|match_i)));
        end
    end

endmodule

// File: rtl/mem_route_decoder.sv
module mem_route_decoder
    import mrd_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int CFG_AW   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NODE_W-1:0] rsp_node,
    output logic [IDX_W-1:0]  rsp_pair
);

    lo_reg_t lo_r [NUM_PAIRS];
    hi_reg_t hi_r [NUM_PAIRS];
    probe_t  probe;

    logic [NUM_PAIRS-1:0]             match;
    logic [NUM_PAIRS-1:0][NODE_W-1:0] nodes;
    logic                             sel_hit;
    logic [NODE_W-1:0]                sel_node;
    logic [IDX_W-1:0]                 sel_idx;

    assign probe = make_probe(req_addr, req_write);

    mrd_regfile #(.NUM_PAIRS(NUM_PAIRS)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lo_o      (lo_r),
        .hi_o      (hi_r)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        mrd_pair_match match_i (
            .lo_i    (lo_r[g]),
            .hi_i    (hi_r[g]),
            .probe_i (probe),
            .match_o (match[g])
        );
        assign nodes[g] = hi_r[g].node;
    end

    mrd_prio_select #(.NUM_PAIRS(NUM_PAIRS)) prio_i (
        .match_i (match),
        .node_i  (nodes),
        .hit_o   (sel_hit),
        .node_o  (sel_node),
        .idx_o   (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_node  <= '0;
            rsp_pair  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && sel_hit;
            rsp_node  <= (req_valid && sel_hit) ? sel_node : '0;
            rsp_pair  <= (req_valid && sel_hit) ? sel_idx  : '0;
        end
    end

    // R1: each request yields a result in the next cycle
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R1: no request, no result
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit));
    // R8: a miss carries zero node and index
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_node == '0 && rsp_pair == '0));

endmodule

// File: tb/mem_route_decoder_tb.sv
module mem_route_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_node, rsp_pair;

    int checks = 0;
    int errors = 0;
    string tag = "R10";
    bit chk_on = 0;

    // behavioural model state
    logic [31:0] m_lo [8];
    logic [31:0] m_hi [8];
    logic        e_valid = 0, e_hit = 0;
    logic [2:0]  e_node = 0, e_pair = 0;

    always #10 clk = ~clk;

    mem_route_decoder dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_pair(rsp_pair)
    );

    function automatic void ref_route(input logic [39:0] a, input logic w,
                                      output logic h, output logic [2:0] n,
                                      output logic [2:0] p);
        h = 0; n = 0; p = 0;
        for (int i = 7; i >= 0; i--) begin
            int lo_b, hi_b, fld, code;
            bit en, legal, ilv;
            en    = w ? m_lo[i][1] : m_lo[i][0];
            lo_b  = int'(m_lo[i][31:16]);
            hi_b  = int'(m_hi[i][31:16]);
            fld   = int'(a[39:24]);
            code  = int'(m_lo[i][10:8]);
            legal = (code == 0) || (code == 1) || (code == 3) || (code == 7);
            ilv   = ((int'(a[14:12]) ^ int'(m_hi[i][10:8])) & code) == 0;
            if (en && legal && ilv && fld >= lo_b && fld <= hi_b) begin
                h = 1; n = m_hi[i][2:0]; p = 3'(i);
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
            e_valid = 0; e_hit = 0; e_node = 0; e_pair = 0;
        end else begin
            logic h; logic [2:0] n, p;
            ref_route(req_addr, req_write, h, n, p);
            e_valid = req_valid;
            e_hit   = req_valid && h;
            e_node  = (req_valid && h) ? n : 3'd0;
            e_pair  = (req_valid && h) ? p : 3'd0;
            if (cfg_we) begin
                if (cfg_addr[3]) m_hi[cfg_addr[2:0]] = cfg_wdata & 32'hFFFF_0707;
                else             m_lo[cfg_addr[2:0]] = cfg_wdata & 32'hFFFF_0703;
            end
            chk_on = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if ({rsp_valid, rsp_hit, rsp_node, rsp_pair} !== {e_valid, e_hit, e_node, e_pair}) begin
                errors++;
                $display("FAIL %s: got v=%0b h=%0b node=%0d pair=%0d, expected v=%0b h=%0b node=%0d pair=%0d",
                         tag, rsp_valid, rsp_hit, rsp_node, rsp_pair, e_valid, e_hit, e_node, e_pair);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rq(input logic [15:0] fld, input logic [2:0] ilv, input logic w);
        req_valid = 1; req_write = w;
        req_addr = {fld, 9'd0, ilv, 12'd0};
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string t);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d read %h, expected %h", t, a, cfg_rdata, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: all registers zero after reset, everything misses
        tag = "R10";
        for (int i = 0; i < 16; i++) rd_chk(4'(i), 32'h0, "R10");
        rq(16'h0000, 3'd0, 0);
        rq(16'h0000, 3'd0, 1);
        @(negedge clk);

        // R9: reserved bits drop out
        tag = "R9";
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'hFFFF_0703, "R9");
        rd_chk(4'h8, 32'hFFFF_0707, "R9");
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h0);
        rd_chk(4'h0, 32'h0, "R9");

        // R2/R3/R4: window 0x08..0x10, node 3, reads only (high-bound first)
        tag = "R2";
        wr(4'h8, 32'h0010_0003);
        wr(4'h0, 32'h0008_0001);
        rq(16'h0007, 0, 0); rq(16'h0008, 0, 0); rq(16'h0010, 0, 0); rq(16'h0011, 0, 0);
        tag = "R3";
        rq(16'h0009, 0, 1);

        // R7: overlapping window 1, 0x00..0x20, node 5, read+write
        tag = "R7";
        wr(4'h9, 32'h0020_0005);
        wr(4'h1, 32'h0000_0003);
        rq(16'h0009, 0, 0); rq(16'h0015, 0, 0); rq(16'h0009, 0, 1);
        tag = "R4";
        rq(16'h0020, 0, 1);
        tag = "R8";
        rq(16'h0021, 0, 0);

        // R5: interleave window 0x40..0x4F, value 101, node 6
        tag = "R5";
        wr(4'hA, 32'h004F_0506);
        wr(4'h2, 32'h0040_0703);
        rq(16'h0044, 3'b101, 0); rq(16'h0044, 3'b100, 0);
        wr(4'h2, 32'h0040_0103);
        rq(16'h0044, 3'b011, 1); rq(16'h0044, 3'b010, 1);
        wr(4'h2, 32'h0040_0303);
        rq(16'h0044, 3'b001, 0); rq(16'h0044, 3'b110, 0);
        // R6: reserved codes never claim
        tag = "R6";
        wr(4'h2, 32'h0040_0203); rq(16'h0044, 3'b101, 0);
        wr(4'h2, 32'h0040_0403); rq(16'h0044, 3'b101, 0);
        wr(4'h2, 32'h0040_0603); rq(16'h0044, 3'b101, 1);

        // R11: write and request in the same cycle
        tag = "R11";
        wr(4'h2, 32'h0040_0003);
        req_valid = 1; req_write = 0; req_addr = {16'h0044, 24'd0};
        cfg_we = 1; cfg_addr = 4'h2; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);

        // R1 and mixed traffic: random requests with occasional writes
        tag = "R1";
        for (int k = 0; k < 600; k++) begin
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = $urandom_range(0, 1) == 1;
            req_addr  = {16'($urandom_range(0, 80)), 9'($urandom), 3'($urandom), 12'($urandom)};
            cfg_we    = ($urandom_range(0, 7) == 0);
            cfg_addr  = 4'($urandom);
            cfg_wdata = {16'($urandom_range(0, 80)), 16'($urandom)};
            @(negedge clk);
        end
        req_valid = 0; cfg_we = 0;
        @(negedge clk);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule